// File: doc/BRIEF.md
# Keypad Event Controller Serial Register Slave

This block is the two-wire serial slave that sits between a host processor and a keypad event controller. It watches the clock and data lines through synchronizers running on a fast system clock. It recognises bus start and stop conditions and compares the address byte with its own 7-bit address. Depending on the direction bit, it either takes in one control byte or streams out a fixed four-byte read burst. On the bus, data is driven only through an active-low open-drain enable.

A read burst always has the same shape. The first byte is the identity byte, which is fixed by a parameter. The second is the control register read-back, which carries the live queue-empty flag. The third is the key code of the oldest queued entry, and the fourth is that entry's duration byte. The host acknowledges bytes to continue the burst. When the host acknowledges the duration byte, the slave sends a one-cycle "entry consumed" pulse to the queue. If the host gives a not-acknowledge, the slave drops off the bus and sends no pulse, so the next read returns the same entry. Two control bits leave the block: one enables the sense-line drive and one requests a full power-down reset of the queue.

Top module: `kp_i2c_slave`

## Requirements
- R1: The slave answers only the 7-bit address formed by binary 01000 followed by `addr_sel[1]` and `addr_sel[0]`. For any other address it never pulls SDA low, and it ignores the bytes that follow until the next START.
- R2: After reset, `drive_en` is 1 and `pwr_down` is 0. The first data byte of a write transaction loads bit 7 into `drive_en` and bit 6 into `pwr_down`. The slave does not acknowledge any further byte in the same transaction, and such a byte has no effect.
- R3: A read transaction (direction bit 1) returns four bytes in this order: identity, control read-back, `q_key`, `q_dur`. Each byte is sent MSB first.
- R4: The identity byte is 0x01 when the parameter `N_KEYS` is greater than 6, and 0x00 otherwise.
- R5: The control read-back byte is {drive_en, pwr_down, q_empty, 5'b00000}. Bits 4..0 read as 0 whatever was written to them.
- R6: `q_pop` pulses high for exactly one system clock when, and only when, the master acknowledges the duration byte.
- R7: A not-acknowledge from the master on any read byte makes the slave release SDA. The slave then stays off the bus until the next START.
- R8: A repeated START at any point restarts address matching, and a new transaction then proceeds normally.
- R9: A STOP releases SDA on the following clock and returns the slave to idle.
- R10: The slave changes `sda_oe` only while the synchronized SCL is low. The slave acknowledges its address and a written byte by holding SDA low through the ninth clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain enable) |
| addr_sel | input | 2 | Pin-selected low address bits |
| q_empty | input | 1 | Event queue holds no entry |
| q_key | input | 8 | Key code of the oldest queue entry |
| q_dur | input | 8 | Duration byte of the oldest queue entry |
| q_pop | output | 1 | One-cycle pulse: entry consumed |
| drive_en | output | 1 | Control bit 7, sense-line drive enable |
| pwr_down | output | 1 | Control bit 6, power-down/queue reset request |

## Verification
On every cycle the assertions check three things. The first is that the slave's drive never changes while SCL is high. The second is that a STOP always releases SDA and that a wrong address never produces an acknowledge. The third is that the consume pulse lasts exactly one cycle, always ends the burst, and that the control outputs move only on a write strobe. Some behaviour only the directed scenarios can show: the byte order and values of a read burst, the identity byte chosen by the parameter, and the read-back masking. The scenarios also show the difference between acknowledging and not acknowledging the duration byte, and recovery after a repeated START or an early STOP.

// File: rtl/kp_i2c_pkg.sv
package kp_i2c_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WR_BYTE,
    ST_WR_ACK,
    ST_RD_BYTE,
    ST_RD_ACK,
    ST_HOLD
  } bus_st_t;

  function automatic logic [6:0] slave_addr(input logic [4:0] pfx, input logic [1:0] pins);
    return {pfx, pins};
  endfunction

  function automatic logic [7:0] ctrl_view(input logic drv, input logic pdn, input logic empty);
    return {drv, pdn, empty, 5'b00000};
  endfunction

  function automatic logic [7:0] ident_byte(input int n_keys);
    return (n_keys > 6) ? 8'h01 : 8'h00;
  endfunction

endpackage

// File: rtl/kp_i2c_sync.sv
module kp_i2c_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic lvl,
  output logic rise,
  output logic fall
);
  localparam int W = STAGES + 1;
  logic [W-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= {W{RST_VAL}};
    else        chain <= {chain[W-2:0], din};
  end

  assign lvl  = chain[STAGES-1];
  assign rise = chain[STAGES-1] & ~chain[STAGES];
  assign fall = ~chain[STAGES-1] & chain[STAGES];
endmodule

// File: rtl/kp_i2c_ctrl.sv
module kp_i2c_ctrl
  import kp_i2c_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic       q_empty,
  output logic       drive_en,
  output logic       pwr_down,
  output logic [7:0] rd_byte
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drive_en <= 1'b1;
      pwr_down <= 1'b0;
    end else if (wr_en) begin
      drive_en <= wr_data[7];
      pwr_down <= wr_data[6];
    end
  end

  assign rd_byte = ctrl_view(drive_en, pwr_down, q_empty);
endmodule

// File: rtl/kp_i2c_slave.sv
module kp_i2c_slave
  import kp_i2c_pkg::*;
#(
  parameter int         N_KEYS      = 30,
  parameter logic [4:0] ADDR_PREFIX = 5'b01000,
  parameter int         SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  input  logic [1:0] addr_sel,
  input  logic       q_empty,
  input  logic [7:0] q_key,
  input  logic [7:0] q_dur,
  output logic       q_pop,
  output logic       drive_en,
  output logic       pwr_down
);
  localparam logic [7:0] ID_BYTE  = ident_byte(N_KEYS);
  localparam logic [1:0] LAST_IDX = 2'd3;

  logic scl_hi, scl_rise, scl_fall;
  logic sda_s, sda_rise, sda_fall;

  kp_i2c_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_scl (
    .clk(clk), .rst_n(rst_n), .din(scl_i), .lvl(scl_hi), .rise(scl_rise), .fall(scl_fall));
  kp_i2c_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_sda (
    .clk(clk), .rst_n(rst_n), .din(sda_i), .lvl(sda_s), .rise(sda_rise), .fall(sda_fall));

  // Named bus events
  logic start_det, stop_det, bus_evt;
  assign start_det = sda_fall & scl_hi;
  assign stop_det  = sda_rise & scl_hi;
  assign bus_evt   = start_det | stop_det;

  bus_st_t    state;
  logic [3:0] bit_cnt;
  logic [7:0] shreg;
  logic       rw_q;
  logic [1:0] byte_idx;
  logic       m_ack_q;

  logic [7:0] ctrl_rd;
  logic       wr_strobe, addr_done, addr_hit, last_ack, hold_state;
  logic [1:0] nxt_idx;
  logic [7:0] nxt_byte;

  assign addr_hit   = (shreg[7:1] == slave_addr(ADDR_PREFIX, addr_sel));
  assign addr_done  = (state == ST_ADDR) && scl_fall && (bit_cnt == 4'd8);
  assign wr_strobe  = (state == ST_WR_BYTE) && scl_fall && (bit_cnt == 4'd8);
  assign last_ack   = (state == ST_RD_ACK) && scl_fall && m_ack_q && (byte_idx == LAST_IDX);
  assign hold_state = (state == ST_HOLD);
  assign q_pop      = last_ack;

  assign nxt_idx = byte_idx + 2'd1;
  always_comb begin
    unique case (nxt_idx)
      2'd0:    nxt_byte = ID_BYTE;
      2'd1:    nxt_byte = ctrl_rd;
      2'd2:    nxt_byte = q_key;
      default: nxt_byte = q_dur;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      bit_cnt  <= '0;
      shreg    <= '0;
      rw_q     <= 1'b0;
      byte_idx <= '0;
      m_ack_q  <= 1'b0;
    end else if (start_det) begin
      state   <= ST_ADDR;
      bit_cnt <= '0;
    end else if (stop_det) begin
      state <= ST_IDLE;
    end else begin
      unique case (state)
        ST_ADDR, ST_WR_BYTE: begin
          if (scl_rise) begin
            shreg   <= {shreg[6:0], sda_s};
            bit_cnt <= bit_cnt + 4'd1;
          end else if (scl_fall && bit_cnt == 4'd8) begin
            bit_cnt <= '0;
            if (state == ST_WR_BYTE) state <= ST_WR_ACK;
            else if (addr_hit) begin
              state <= ST_ADDR_ACK;
              rw_q  <= shreg[0];
            end else state <= ST_IDLE;
          end
        end
        ST_ADDR_ACK: begin
          if (scl_fall) begin
            bit_cnt <= '0;
            if (rw_q) begin
              state    <= ST_RD_BYTE;
              byte_idx <= '0;
              shreg    <= ID_BYTE;
            end else state <= ST_WR_BYTE;
          end
        end
        ST_WR_ACK: if (scl_fall) state <= ST_HOLD;
        ST_RD_BYTE: begin
          if (scl_fall) begin
            if (bit_cnt == 4'd7) begin
              state   <= ST_RD_ACK;
              bit_cnt <= '0;
            end else begin
              shreg   <= {shreg[6:0], 1'b0};
              bit_cnt <= bit_cnt + 4'd1;
            end
          end
        end
        ST_RD_ACK: begin
          if (scl_rise) m_ack_q <= ~sda_s;
          else if (scl_fall) begin
            if (!m_ack_q)                  state <= ST_IDLE;
            else if (byte_idx == LAST_IDX) state <= ST_HOLD;
            else begin
              state    <= ST_RD_BYTE;
              byte_idx <= nxt_idx;
              shreg    <= nxt_byte;
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign sda_oe = (state == ST_ADDR_ACK) || (state == ST_WR_ACK) ||
                  ((state == ST_RD_BYTE) && !shreg[7]);

  kp_i2c_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_strobe), .wr_data(shreg), .q_empty(q_empty),
    .drive_en(drive_en), .pwr_down(pwr_down), .rd_byte(ctrl_rd));
endmodule

// File: rtl/kp_i2c_slave_chk.sv
module kp_i2c_slave_chk (
  input logic clk,
  input logic rst_n,
  input logic sda_oe,
  input logic q_pop,
  input logic drive_en,
  input logic pwr_down,
  input logic scl_hi,
  input logic bus_evt,
  input logic stop_det,
  input logic addr_done,
  input logic addr_hit,
  input logic wr_strobe,
  input logic hold_state
);
  // R10: drive only changes while SCL is low
  assert_oe_stable_scl_high_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_hi && $past(scl_hi) && !$past(bus_evt)) |-> $stable(sda_oe));

  // R9: STOP releases the bus
  assert_stop_releases_R9: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_oe);

  // R1: wrong address never acknowledged
  assert_no_ack_on_miss_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_done && !addr_hit && !bus_evt) |=> !sda_oe);

  // R6: consume pulse is one cycle wide and ends the burst
  assert_pop_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    q_pop |=> !q_pop);
  assert_pop_ends_burst_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (q_pop && !bus_evt) |=> hold_state);

  // R2: control outputs move only on a write strobe
  assert_ctrl_only_on_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_strobe |=> $stable({drive_en, pwr_down}));
endmodule

bind kp_i2c_slave kp_i2c_slave_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sda_oe(sda_oe), .q_pop(q_pop), .drive_en(drive_en),
  .pwr_down(pwr_down), .scl_hi(scl_hi), .bus_evt(bus_evt), .stop_det(stop_det),
  .addr_done(addr_done), .addr_hit(addr_hit), .wr_strobe(wr_strobe),
  .hold_state(hold_state));

// File: tb/tb_kp_i2c_slave.sv
`timescale 1ns/1ps
module tb_kp_i2c_slave;
  localparam int N_KEYS = 30;
  localparam int Q      = 6;
  localparam logic [7:0] EXP_ID = (N_KEYS > 6) ? 8'h01 : 8'h00;
  localparam logic [1:0] PINS   = 2'b10;
  localparam logic [7:0] AW     = {5'b01000, PINS, 1'b0};
  localparam logic [7:0] AR     = {5'b01000, PINS, 1'b1};

  logic clk = 0, rst_n = 0;
  logic scl = 1, sda_m = 1;
  logic q_empty = 1;
  logic [7:0] q_key = 8'h00, q_dur = 8'h00;
  wire  sda_oe, q_pop, drive_en, pwr_down;
  wire  sda_line = sda_m & ~sda_oe;

  int n_tests = 0, n_fail = 0, pop_cnt = 0, cyc = 0;
  logic oe_seen = 0;

  always #5 clk = ~clk;

  kp_i2c_slave #(.N_KEYS(N_KEYS)) dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .sda_oe(sda_oe),
    .addr_sel(PINS), .q_empty(q_empty), .q_key(q_key), .q_dur(q_dur),
    .q_pop(q_pop), .drive_en(drive_en), .pwr_down(pwr_down));

  always @(posedge clk) begin
    if (q_pop) pop_cnt <= pop_cnt + 1;
    if (sda_oe) oe_seen <= 1'b1;
  end

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: act=timeout exp=done");
      summary();
    end
  end

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wq(); repeat (Q) @(negedge clk); endtask

  task automatic bit_x(input logic b, output logic s);
    sda_m = b; wq(); scl = 1; wq(); s = sda_line; wq(); scl = 0; wq();
  endtask

  task automatic i2c_start();
    sda_m = 1; wq(); scl = 1; wq(); sda_m = 0; wq(); scl = 0; wq();
  endtask

  task automatic i2c_stop();
    sda_m = 0; wq(); scl = 1; wq(); sda_m = 1; wq(); wq();
  endtask

  task automatic wr_byte(input logic [7:0] b, output logic nak);
    logic d;
    for (int i = 7; i >= 0; i--) bit_x(b[i], d);
    bit_x(1'b1, nak);
  endtask

  task automatic rd_byte(input logic ack, output logic [7:0] b);
    logic d;
    for (int i = 7; i >= 0; i--) bit_x(1'b1, b[i]);
    bit_x(~ack, d);
  endtask

  task automatic write_ctrl(input logic [7:0] v);
    logic n;
    i2c_start(); wr_byte(AW, n); wr_byte(v, n); i2c_stop();
  endtask

  task automatic t_reset();
    check("R2 reset drive_en", {7'b0, drive_en}, 8'h01);
    check("R2 reset pwr_down", {7'b0, pwr_down}, 8'h00);
    check("R9 reset sda_oe", {7'b0, sda_oe}, 8'h00);
    check("R6 reset q_pop", {7'b0, q_pop}, 8'h00);
  endtask

  task automatic t_write_and_readback();
    logic n1, n2; logic [7:0] b;
    i2c_start(); wr_byte(AW, n1); wr_byte(8'h5A, n2); i2c_stop();
    check("R1 address ack", {7'b0, n1}, 8'h00);
    check("R10 data ack", {7'b0, n2}, 8'h00);
    check("R2 drive_en loaded", {7'b0, drive_en}, 8'h00);
    check("R2 pwr_down loaded", {7'b0, pwr_down}, 8'h01);
    q_empty = 1;
    i2c_start(); wr_byte(AR, n1); rd_byte(1, b); rd_byte(0, b); i2c_stop();
    check("R5 ctrl readback masked", b, 8'h60);
  endtask

  task automatic t_extra_write();
    logic n1, n2, n3;
    i2c_start(); wr_byte(AW, n1); wr_byte(8'hC0, n2); wr_byte(8'h00, n3); i2c_stop();
    check("R2 extra byte nacked", {7'b0, n3}, 8'h01);
    check("R2 extra byte ignored", {6'b0, drive_en, pwr_down}, 8'h03);
  endtask

  task automatic t_burst();
    logic n; logic [7:0] id, c, k, d; int p0;
    write_ctrl(8'h9F);
    q_empty = 0; q_key = 8'hA5; q_dur = 8'h83; p0 = pop_cnt;
    i2c_start(); wr_byte(AR, n);
    rd_byte(1, id); rd_byte(1, c); rd_byte(1, k); rd_byte(1, d); i2c_stop();
    check("R4 identity byte", id, EXP_ID);
    check("R3 ctrl byte", c, 8'h80);
    check("R3 key byte", k, 8'hA5);
    check("R3 duration byte", d, 8'h83);
    check("R6 pop on ack", pop_cnt - p0, 1);
  endtask

  task automatic t_nack_duration();
    logic n; logic [7:0] id, c, k, d; int p0;
    q_key = 8'h3C; q_dur = 8'h01; p0 = pop_cnt;
    i2c_start(); wr_byte(AR, n);
    rd_byte(1, id); rd_byte(1, c); rd_byte(1, k); rd_byte(0, d);
    check("R6 no pop on nack", pop_cnt - p0, 0);
    oe_seen = 0;
    for (int i = 0; i < 9; i++) bit_x(1'b1, n);
    check("R7 released after nack", {7'b0, oe_seen}, 8'h00);
    i2c_stop();
    i2c_start(); wr_byte(AR, n);
    rd_byte(1, id); rd_byte(1, c); rd_byte(1, k); rd_byte(1, d); i2c_stop();
    check("R6 same entry again", k, 8'h3C);
    check("R6 pop after ack", pop_cnt - p0, 1);
  endtask

  task automatic t_mismatch();
    logic n;
    oe_seen = 0;
    i2c_start(); wr_byte(8'h40, n); wr_byte(8'h00, n); i2c_stop();
    check("R1 miss no drive", {7'b0, oe_seen}, 8'h00);
    check("R1 miss ctrl unchanged", {6'b0, drive_en, pwr_down}, 8'h02);
  endtask

  task automatic t_restart();
    logic n; logic [7:0] id;
    i2c_start(); wr_byte(AW, n);
    i2c_start(); wr_byte(AR, n);
    check("R8 restart addr ack", {7'b0, n}, 8'h00);
    rd_byte(0, id); i2c_stop();
    check("R8 restart read id", id, EXP_ID);
  endtask

  task automatic t_early_stop();
    logic n, d;
    i2c_start(); wr_byte(AW, n); bit_x(1'b0, d); bit_x(1'b1, d); i2c_stop();
    repeat (2) @(negedge clk);
    check("R9 released after stop", {7'b0, sda_oe}, 8'h00);
    check("R9 partial byte no write", {6'b0, drive_en, pwr_down}, 8'h02);
    write_ctrl(8'h40);
    check("R9 next transaction works", {6'b0, drive_en, pwr_down}, 8'h01);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1;
    repeat (5) @(negedge clk);
    t_reset();
    t_write_and_readback();
    t_extra_write();
    t_burst();
    t_nack_duration();
    t_mismatch();
    t_restart();
    t_early_stop();
    summary();
  end
endmodule